// File: doc/BRIEF.md
# Pixel Input FIFO with Unpacker

This block buffers packed, encoded pixel words fetched from a frame buffer and hands them on one pixel at a time. Storage is five 32-bit entries arranged as a shift-down queue: the oldest word always sits in entry 0, and when its last pixel is taken, the remaining entries each move down one place. While a word is stored, it stays packed. It is split into pixels only as it leaves the bottom entry.

A refill request goes to the memory fetch engine whenever at least four entries are empty, so that the engine can answer with a four-word burst. On the read side, a valid/ready pixel stream carries 4-, 8-, 12- or 16-bit pixels, chosen by a depth mode input. The stream also carries a width tag and a flag that sends 12-bit pixels to the dither path instead of the colour lookup.

Top module: `pix_fifo_unpack`

## Requirements
- R1: The queue holds up to 5 words. A word pushed into an empty queue appears at the pixel output in the cycle after the push edge.
- R2: `dma_req_o` is high exactly when at least four of the five entries are empty, that is when 0 or 1 words are held.
- R3: A push while 5 words are held is ignored, even if a word leaves in the same cycle. It sets `overflow_o`, which stays high until reset.
- R4: Words leave in arrival order. Within a word, pixels are taken from the least significant end upward.
- R5: Mode code 0 (4 bpp) gives 8 pixels per word. Pixel k is bits [4k+3:4k], zero-extended on `pix_data_o`.
- R6: Mode code 1 (8 bpp) gives 4 pixels per word. Pixel k is bits [8k+7:8k], zero-extended.
- R7: Mode code 2 (12 bpp) gives 2 pixels per word. Pixel k is bits [16k+11:16k], zero-extended, and `pix_to_dither_o` is high. `pix_width_o` always equals the mode code.
- R8: Mode code 3 (16 bpp) gives 2 pixels per word. Pixel k is bits [16k+15:16k].
- R9: A pixel advances only on a cycle with `pix_valid_o` and `pix_ready_i` both high. While the stream is stalled, the pixel is held. A word is removed only after its last pixel is taken.
- R10: After reset the queue is empty, `pix_valid_o` is low, `dma_req_o` is high and `overflow_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Write one word |
| push_data_i | input | 32 | Packed pixel word |
| mode_i | input | 2 | Depth mode: 0=4, 1=8, 2=12, 3=16 bits |
| pix_ready_i | input | 1 | Consumer takes the current pixel |
| pix_valid_o | output | 1 | A pixel is available |
| pix_data_o | output | 16 | Current pixel, zero-extended |
| pix_width_o | output | 2 | Width tag (mode code) |
| pix_to_dither_o | output | 1 | Pixel bound for the dither path |
| dma_req_o | output | 1 | Refill request |
| overflow_o | output | 1 | Sticky push-while-full flag |

## Verification
The assertions take for granted that `mode_i` changes only while the queue is empty. A mode change in the middle of a word would reinterpret the pixel slot in use, so the stall-hold property allows for a change of mode. The stimulus respects this assumption. It sets a mode, runs random pushes and random ready for a while, then drains the queue with pushes off before it picks the next mode. The overflow and full-queue cases are driven on purpose by pushing with ready held low.

// File: rtl/pix_fifo_pkg.sv
package pix_fifo_pkg;
  typedef enum logic [1:0] {
    PM_4  = 2'd0,
    PM_8  = 2'd1,
    PM_12 = 2'd2,
    PM_16 = 2'd3
  } pix_mode_e;
endpackage

// File: rtl/pix_word_store.sv
module pix_word_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              overflow_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic              full, push_ok, pop_ok;
  logic [CNT_W-1:0]  wr_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign wr_idx  = pop_ok ? cnt_q - 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (pop_ok)
        for (int i = 0; i < DEPTH - 1; i++) mem_q[i] <= mem_q[i+1];
      if (push_ok) mem_q[wr_idx[IDX_W-1:0]] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign head_o     = mem_q[0];
  assign count_o    = cnt_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
  import pix_fifo_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 16,
  localparam int NIB_N  = WORD_W / 4,
  localparam int BYTE_N = WORD_W / 8,
  localparam int HALF_N = WORD_W / 16,
  localparam int SLOT_W = $clog2(NIB_N),
  localparam int BSEL_W = $clog2(BYTE_N),
  localparam int HSEL_W = $clog2(HALF_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pix_mode_e         mode_i,
  input  logic              word_avail_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              pix_ready_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_data_o,
  output logic              word_done_o
);
  logic [3:0]  nib  [NIB_N];
  logic [7:0]  byt  [BYTE_N];
  logic [15:0] half [HALF_N];
  logic [SLOT_W-1:0] slot_q, last_slot;
  logic fire, last;

  for (genvar k = 0; k < NIB_N; k++) begin : g_nib
    assign nib[k] = word_i[4*k +: 4];
  end
  for (genvar k = 0; k < BYTE_N; k++) begin : g_byte
    assign byt[k] = word_i[8*k +: 8];
  end
  for (genvar k = 0; k < HALF_N; k++) begin : g_half
    assign half[k] = word_i[16*k +: 16];
  end

  always_comb begin
    unique case (mode_i)
      PM_4:    last_slot = SLOT_W'(NIB_N - 1);
      PM_8:    last_slot = SLOT_W'(BYTE_N - 1);
      default: last_slot = SLOT_W'(HALF_N - 1);
    endcase
  end

  always_comb begin
    pix_data_o = '0;
    unique case (mode_i)
      PM_4:  pix_data_o[3:0]  = nib[slot_q];
      PM_8:  pix_data_o[7:0]  = byt[slot_q[BSEL_W-1:0]];
      PM_12: pix_data_o[11:0] = half[slot_q[HSEL_W-1:0]][11:0];
      PM_16: pix_data_o[15:0] = half[slot_q[HSEL_W-1:0]];
      default: pix_data_o = '0;
    endcase
  end

  assign pix_valid_o = word_avail_i;
  assign fire        = word_avail_i && pix_ready_i;
  assign last        = (slot_q == last_slot);
  assign word_done_o = fire && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    slot_q <= '0;
    else if (fire)  slot_q <= last ? '0 : slot_q + 1'b1;
  end
endmodule

// File: rtl/pix_fifo_unpack.sv
module pix_fifo_unpack
  import pix_fifo_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 5,
  parameter int REQ_EMPTY = 4,
  parameter int PIX_W     = 16,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic [1:0]        mode_i,
  input  logic              pix_ready_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_data_o,
  output logic [1:0]        pix_width_o,
  output logic              pix_to_dither_o,
  output logic              dma_req_o,
  output logic              overflow_o
);
  pix_mode_e         mode;
  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0]  count;
  logic              word_done;

  assign mode = pix_mode_e'(mode_i);

  pix_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .push_i, .push_data_i,
    .pop_i(word_done), .head_o(head), .count_o(count), .overflow_o
  );

  pix_unpacker #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_unpack (
    .clk_i, .rst_ni, .mode_i(mode),
    .word_avail_i(count != '0), .word_i(head),
    .pix_ready_i, .pix_valid_o, .pix_data_o, .word_done_o(word_done)
  );

  // empty slots = DEPTH - count
  assign dma_req_o       = (CNT_W'(DEPTH) - count) >= CNT_W'(REQ_EMPTY);
  assign pix_width_o     = mode_i;
  assign pix_to_dither_o = (mode == PM_12);
endmodule

// File: rtl/pix_fifo_unpack_chk.sv
module pix_fifo_unpack_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        push_i,
  input logic [1:0]  mode_i,
  input logic        pix_ready_i,
  input logic        pix_valid_o,
  input logic [15:0] pix_data_o,
  input logic        pix_to_dither_o,
  input logic        dma_req_o,
  input logic        overflow_o
);
  assert_empty_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> dma_req_o);
  assert_ovf_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  assert_ovf_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(push_i));
  assert_nib_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && mode_i == 2'd0) |-> pix_data_o[15:4] == 12'h0);
  assert_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && mode_i == 2'd1) |-> pix_data_o[15:8] == 8'h0);
  assert_dither_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && pix_to_dither_o) |-> pix_data_o[15:12] == 4'h0);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |=>
      (pix_valid_o && ($stable(pix_data_o) || !$stable(mode_i))));
endmodule

bind pix_fifo_unpack pix_fifo_unpack_chk u_chk (
  .clk_i, .rst_ni, .push_i, .mode_i, .pix_ready_i, .pix_valid_o,
  .pix_data_o, .pix_to_dither_o, .dma_req_o, .overflow_o
);

// File: tb/sim_pix_fifo_unpack.sv
module sim_pix_fifo_unpack;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        push_i = 1'b0, pix_ready_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic [1:0]  mode_i = 2'd0;
  logic        pix_valid_o, pix_to_dither_o, dma_req_o, overflow_o;
  logic [15:0] pix_data_o;
  logic [1:0]  pix_width_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] q[$];
  int slot = 0;
  bit ovf_m = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pix_fifo_unpack u0 (.*);

  function automatic int ppw(logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 4 : 2;
  endfunction

  function automatic logic [15:0] exp_pix(logic [31:0] w, logic [1:0] m, int k);
    case (m)
      2'd0:    return 16'(( w >> (4*k))  & 32'hF);
      2'd1:    return 16'(( w >> (8*k))  & 32'hFF);
      2'd2:    return 16'(( w >> (16*k)) & 32'hFFF);
      default: return 16'(( w >> (16*k)) & 32'hFFFF);
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 valid", 32'(pix_valid_o), 32'(q.size() > 0));
    chk("R2 dma_req", 32'(dma_req_o), 32'(q.size() <= 1));
    chk("R3 overflow", 32'(overflow_o), 32'(ovf_m));
    chk("R7 width tag", 32'(pix_width_o), 32'(mode_i));
    chk("R7 dither", 32'(pix_to_dither_o), 32'(mode_i == 2'd2));
    if (q.size() > 0)
      chk(mode_i == 0 ? "R4 R5 pix" : mode_i == 1 ? "R4 R6 pix" :
          mode_i == 2 ? "R4 R7 pix" : "R4 R8 pix",
          32'(pix_data_o), 32'(exp_pix(q[0], mode_i, slot)));
  endtask

  // called just after a negedge
  task automatic step(bit p, logic [31:0] d, bit r);
    int sz;
    compare();
    push_i = p; push_data_i = d; pix_ready_i = r;
    @(posedge clk_i);
    sz = q.size();
    if (sz > 0 && r) begin  // R9 advance only on fire
      if (slot == ppw(mode_i) - 1) begin void'(q.pop_front()); slot = 0; end
      else slot++;
    end
    if (p) begin
      if (sz < 5) q.push_back(d);
      else ovf_m = 1;
    end
    @(negedge clk_i);
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && q.size() > 0; i++) step(0, '0, 1);
  endtask

  task automatic do_reset();
    rst_ni = 0; push_i = 0; pix_ready_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    q.delete(); slot = 0; ovf_m = 0;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog act timeout exp done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    // R10 reset state
    chk("R10 valid", 32'(pix_valid_o), 0);
    chk("R10 dma_req", 32'(dma_req_o), 1);
    chk("R10 overflow", 32'(overflow_o), 0);

    // R1 R2: fill to capacity with consumer stalled, then over-push (R3)
    mode_i = 2'd0;
    for (int i = 0; i < 5; i++) step(1, 32'h8765_4321 + 32'(i) * 32'h1111_1111, 0);
    chk("R1 full valid", 32'(pix_valid_o), 1);
    chk("R2 full no req", 32'(dma_req_o), 0);
    step(1, 32'hDEAD_BEEF, 0);
    chk("R3 overflow set", 32'(overflow_o), 1);
    // R3: push with simultaneous word completion while full is still dropped
    for (int i = 0; i < 7; i++) step(0, '0, 1);
    step(1, 32'hCAFE_F00D, 1);
    chk("R3 full+pop push dropped", 32'(q.size()), 4);
    // R9: stall holds pixel
    step(0, '0, 0); step(0, '0, 0);
    drain();
    chk("R4 drained", 32'(pix_valid_o), 0);

    // random per mode
    for (int m = 0; m < 4; m++) begin
      mode_i = 2'(m);
      for (int c = 0; c < 2000; c++)
        step(($urandom % 100) < 45, $urandom, ($urandom % 100) < 60);
      drain();
    end

    // directed 16 bpp and 12 bpp patterns
    mode_i = 2'd3;
    step(1, 32'hA5A5_F00F, 0);
    chk("R8 low half", 32'(pix_data_o), 32'hF00F);
    step(0, '0, 1);
    chk("R8 high half", 32'(pix_data_o), 32'hA5A5);
    drain();
    mode_i = 2'd2;
    step(1, 32'hFABC_E123, 0);
    chk("R7 low 12", 32'(pix_data_o), 32'h0123);
    step(0, '0, 1);
    chk("R7 high 12", 32'(pix_data_o), 32'h0ABC);
    drain();

    // overflow clears only on reset
    chk("R3 still set", 32'(overflow_o), 1);
    do_reset();
    chk("R10 overflow cleared", 32'(overflow_o), 0);
    chk("R10 req after reset", 32'(dma_req_o), 1);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule